// File: doc/BRIEF.md
# Overcurrent Leaky Fault Timer

This block decides when a powered port has drawn too much current for too long. On every valid sample it compares a digitized output-current reading against an overload threshold. The threshold depends on the power level granted to the port. Samples above the threshold push a timer up by one step. Samples at or below it let the timer bleed back toward zero, but sixteen times more slowly. When the accumulated count reaches the trip point (60 ms worth of samples), an overcurrent fault is latched.

A separate short-circuit path needs no time at all. A single sample above the short limit, or a low-output-voltage indication, latches a short flag. Either flag raises a shutdown request. The converter logic downstream acts on that request by stopping its clock first and then opening the pass switch.

The surrounding controller drives the enable and clear inputs. With enable low, the timer is held at zero and samples are ignored. Clear wipes both flags and the timer.

Top module: `ocp_leaky_timer`

## Requirements
- R1: After reset, `ocp_fault_o`, `short_fault_o` and `shutdown_req_o` are 0 and `ocp_tmr_o` is 0.
- R2: A valid sample strictly greater than the selected threshold raises `ocp_tmr_o` by one on the next clock edge. The threshold is chosen by `pwr_lvl_i` as follows: 0 selects 400, 1 selects 98, 2 selects 180 and 3 selects 98. A sample equal to the threshold counts as below it.
- R3: Valid samples at or below the threshold lower the timer by one on every 16th consecutive such sample. Any above-threshold sample restarts that count of sixteen.
- R4: The timer never goes below zero. Below-threshold samples taken at zero leave it at zero.
- R5: The above-threshold sample that brings the timer to TRIP_TICKS (default 60) sets `ocp_fault_o` on the same edge, with `ocp_tmr_o` = TRIP_TICKS. The timer never exceeds TRIP_TICKS.
- R6: A short condition sets `short_fault_o` on the next edge. A short condition is either of these: a valid sample above 800 while enabled, or `vout_low_i` high while enabled. A sample of exactly 800 does not set it.
- R7: Both fault flags stay set until `clr_i` is asserted. A clear takes priority over every other input and zeroes both flags, the timer and the decrement count.
- R8: While `en_i` is low, the timer is zero and samples, including short-level samples and `vout_low_i`, change no flag.
- R9: `shutdown_req_o` is high exactly when either fault flag is high.
- R10: In a cycle with `sample_vld_i` low, the timer and the flags keep their values, whatever `isense_i` holds.
- R11: While either fault flag is set, further samples do not move the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| isense_i | input | CUR_W | Digitized output current, 1 LSB per mA |
| sample_vld_i | input | 1 | Sample strobe, one per timer tick |
| pwr_lvl_i | input | 2 | Granted power level, selects the overload threshold |
| vout_low_i | input | 1 | Output voltage below the collapse limit |
| en_i | input | 1 | Port powered; low holds the timer at zero |
| clr_i | input | 1 | Clears the flags and the timer |
| ocp_fault_o | output | 1 | Latched overcurrent (timed) fault |
| short_fault_o | output | 1 | Latched immediate short fault |
| shutdown_req_o | output | 1 | Request to shut the converter down |
| ocp_tmr_o | output | TMR_W | Current value of the leaky timer |

## Verification
A wrong threshold decode or comparator shows on `ocp_tmr_o` at the very next edge after the first sample near the boundary. A decrement prescaler that is stuck, or that is not restarted, misplaces a timer decrement within at most sixteen below-threshold samples. A timer that drifts or saturates badly moves the fault edge away from exactly the sixtieth net up-step, which the bench sees on the edge where the flag rises. Flag latching and freezing errors show on the first sample after a trip, because a sample then either moves the timer or drops a flag.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Power-level codes presented on pwr_lvl_i
  typedef enum logic [1:0] {
    LVL_FULL  = 2'd0,
    LVL_C1    = 2'd1,
    LVL_C12   = 2'd2,
    LVL_SPARE = 2'd3
  } pwr_lvl_e;

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/ocp_thresh_sel.sv
module ocp_thresh_sel
  import ocp_pkg::*;
#(
  parameter int CUR_W    = 10,
  parameter int THR_FULL = 400,
  parameter int THR_C1   = 98,
  parameter int THR_C12  = 180
) (
  input  logic [1:0]       lvl_i,
  output logic [CUR_W-1:0] thr_o
);

  always_comb begin
    case (pwr_lvl_e'(lvl_i))
      LVL_FULL:  thr_o = CUR_W'(THR_FULL);
      LVL_C1:    thr_o = CUR_W'(THR_C1);
      LVL_C12:   thr_o = CUR_W'(THR_C12);
      // unused code falls back to the most restrictive grant
      LVL_SPARE: thr_o = CUR_W'(THR_C1);
      default:   thr_o = CUR_W'(THR_C1);
    endcase
  end

endmodule

// File: rtl/ocp_leaky_cnt.sv
module ocp_leaky_cnt #(
  parameter int  TRIP_TICKS = 60,
  parameter int  DIV_LOG2   = 4,
  localparam int TMR_W      = $clog2(TRIP_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             trip_o
);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             dec_go;

  generate
    if (DIV_LOG2 > 0) begin : g_pre
      logic [DIV_LOG2-1:0] pre_q, pre_d;
      logic                pre_en;

      always_comb begin
        pre_d  = pre_q;
        pre_en = clr_i || !en_i || up_i || dn_i;
        if (clr_i || !en_i || up_i) begin
          pre_d = '0;
        end else if (dn_i) begin
          pre_d = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign dec_go = dn_i && (pre_q == {DIV_LOG2{1'b1}});
    end else begin : g_nopre
      assign dec_go = dn_i;
    end
  endgenerate

  assign trip_o = up_i && (tmr_q >= TMR_W'(TRIP_TICKS - 1));

  always_comb begin
    tmr_d  = tmr_q;
    tmr_en = clr_i || !en_i || up_i || dec_go;
    if (clr_i || !en_i) begin
      tmr_d = '0;
    end else if (up_i) begin
      tmr_d = trip_o ? TMR_W'(TRIP_TICKS) : tmr_q + 1'b1;
    end else if (dec_go && (tmr_q != '0)) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign tmr_o = tmr_q;

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trip_set_i,
  input  logic short_set_i,
  output logic fault_o,
  output logic short_o
);

  logic fault_q, fault_d;
  logic short_q, short_d;
  logic flag_en;

  always_comb begin
    flag_en = clr_i || trip_set_i || short_set_i;
    fault_d = clr_i ? 1'b0 : (fault_q || trip_set_i);
    short_d = clr_i ? 1'b0 : (short_q || short_set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      short_q <= 1'b0;
    end else if (flag_en) begin
      fault_q <= fault_d;
      short_q <= short_d;
    end
  end

  assign fault_o = fault_q;
  assign short_o = short_q;

endmodule

// File: rtl/ocp_leaky_timer.sv
module ocp_leaky_timer #(
  parameter int  CUR_W      = 10,
  parameter int  TRIP_TICKS = 60,
  parameter int  DIV_LOG2   = 4,
  parameter int  THR_FULL   = 400,
  parameter int  THR_C1     = 98,
  parameter int  THR_C12    = 180,
  parameter int  SHORT_THR  = 800,
  localparam int TMR_W      = $clog2(TRIP_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] isense_i,
  input  logic             sample_vld_i,
  input  logic [1:0]       pwr_lvl_i,
  input  logic             vout_low_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             ocp_fault_o,
  output logic             short_fault_o,
  output logic             shutdown_req_o,
  output logic [TMR_W-1:0] ocp_tmr_o
);

  logic             rst_sync_n;
  logic [CUR_W-1:0] thr;
  logic             live, sample, above;
  logic             step_up, step_dn;
  logic             trip_hit, short_set;
  logic             fault_q, short_q;

  ocp_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ocp_thresh_sel #(
    .CUR_W    (CUR_W),
    .THR_FULL (THR_FULL),
    .THR_C1   (THR_C1),
    .THR_C12  (THR_C12)
  ) u_thr (
    .lvl_i (pwr_lvl_i),
    .thr_o (thr)
  );

  // a sample counts only while powered, not clearing and not tripped
  always_comb begin
    live      = en_i && !clr_i && !(fault_q || short_q);
    sample    = sample_vld_i && live;
    above     = isense_i > thr;
    step_up   = sample && above;
    step_dn   = sample && !above;
    short_set = en_i && !clr_i &&
                (vout_low_i || (sample_vld_i && (isense_i > CUR_W'(SHORT_THR))));
  end

  ocp_leaky_cnt #(
    .TRIP_TICKS (TRIP_TICKS),
    .DIV_LOG2   (DIV_LOG2)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .tmr_o  (ocp_tmr_o),
    .trip_o (trip_hit)
  );

  ocp_trip_latch u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clr_i       (clr_i),
    .trip_set_i  (trip_hit),
    .short_set_i (short_set),
    .fault_o     (fault_q),
    .short_o     (short_q)
  );

  assign ocp_fault_o    = fault_q;
  assign short_fault_o  = short_q;
  assign shutdown_req_o = fault_q || short_q;

endmodule

// File: rtl/ocp_leaky_timer_chk.sv
module ocp_leaky_timer_chk #(
  parameter int CUR_W      = 10,
  parameter int TRIP_TICKS = 60,
  parameter int SHORT_THR  = 800,
  parameter int TMR_W      = 6
) (
  input logic             clk_i,
  input logic             rst_ok_ni,
  input logic [CUR_W-1:0] isense_i,
  input logic             sample_vld_i,
  input logic             vout_low_i,
  input logic             en_i,
  input logic             clr_i,
  input logic             ocp_fault_o,
  input logic             short_fault_o,
  input logic             shutdown_req_o,
  input logic [TMR_W-1:0] ocp_tmr_o
);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    ocp_tmr_o <= TMR_W'(TRIP_TICKS)); // R5

  AST_TMR_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    (en_i && !clr_i) |=> (ocp_tmr_o == $past(ocp_tmr_o)) ||
                         (ocp_tmr_o == TMR_W'($past(ocp_tmr_o) + 1'b1)) ||
                         (ocp_tmr_o == TMR_W'($past(ocp_tmr_o) - 1'b1))); // R3

  AST_FAULT_AT_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    $rose(ocp_fault_o) |-> (ocp_tmr_o == TMR_W'(TRIP_TICKS))); // R5

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    (ocp_fault_o && !clr_i) |=> ocp_fault_o); // R7

  AST_SHORT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    (short_fault_o && !clr_i) |=> short_fault_o); // R7

  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    clr_i |=> (!ocp_fault_o && !short_fault_o && (ocp_tmr_o == '0))); // R7

  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    !en_i |=> (ocp_tmr_o == '0)); // R8

  AST_SHORT_NOW: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    (en_i && !clr_i && sample_vld_i && (isense_i > CUR_W'(SHORT_THR))) |=> short_fault_o); // R6

  AST_SHUTDOWN_ON_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    ($rose(ocp_fault_o) || $rose(short_fault_o)) |-> shutdown_req_o); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    (en_i && !clr_i && !sample_vld_i && !vout_low_i) |=>
      ($stable(ocp_tmr_o) && $stable(ocp_fault_o) && $stable(short_fault_o))); // R10

  AST_TRIP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ok_ni)
    ((ocp_fault_o || short_fault_o) && en_i && !clr_i) |=> $stable(ocp_tmr_o)); // R11

endmodule

bind ocp_leaky_timer ocp_leaky_timer_chk #(
  .CUR_W      (CUR_W),
  .TRIP_TICKS (TRIP_TICKS),
  .SHORT_THR  (SHORT_THR),
  .TMR_W      (TMR_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ok_ni      (rst_sync_n),
  .isense_i       (isense_i),
  .sample_vld_i   (sample_vld_i),
  .vout_low_i     (vout_low_i),
  .en_i           (en_i),
  .clr_i          (clr_i),
  .ocp_fault_o    (ocp_fault_o),
  .short_fault_o  (short_fault_o),
  .shutdown_req_o (shutdown_req_o),
  .ocp_tmr_o      (ocp_tmr_o)
);

// File: tb/ocp_leaky_timer_tb.sv
`timescale 1ns/1ps
module ocp_leaky_timer_tb_top;

  localparam int TRIP = 60;
  localparam int SHRT = 800;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] isense;
  logic       vld, vlow, en, clr;
  logic [1:0] lvl;
  logic       flt, sht, shdn;
  logic [5:0] tmr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // expected state
  int e_tmr = 0, e_pre = 0;
  bit e_flt = 1'b0, e_sht = 1'b0;

  always #2 clk = ~clk;

  ocp_leaky_timer #(.TRIP_TICKS(TRIP)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .isense_i       (isense),
    .sample_vld_i   (vld),
    .pwr_lvl_i      (lvl),
    .vout_low_i     (vlow),
    .en_i           (en),
    .clr_i          (clr),
    .ocp_fault_o    (flt),
    .short_fault_o  (sht),
    .shutdown_req_o (shdn),
    .ocp_tmr_o      (tmr)
  );

  function automatic int thr_of(int l);
    case (l)
      0: return 400;
      2: return 180;
      default: return 98;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare at the following negedge
  task automatic step(input int cur, input bit v, input bit c, input bit vl, input string tag);
    bit tripped;
    isense = 10'(cur); vld = v; clr = c; vlow = vl;
    if (c) begin
      e_tmr = 0; e_pre = 0; e_flt = 0; e_sht = 0;
    end else if (!en) begin
      e_tmr = 0; e_pre = 0;
    end else begin
      tripped = e_flt || e_sht;
      if (vl || (v && cur > SHRT)) e_sht = 1;
      if (v && !tripped) begin
        if (cur > thr_of(int'(lvl))) begin
          e_pre = 0;
          if (e_tmr + 1 >= TRIP) begin e_tmr = TRIP; e_flt = 1; end
          else e_tmr = e_tmr + 1;
        end else if (e_pre == 15) begin
          e_pre = 0;
          if (e_tmr > 0) e_tmr = e_tmr - 1;
        end else begin
          e_pre = e_pre + 1;
        end
      end
    end
    @(negedge clk);
    n_chk++;
    if (int'(tmr) != e_tmr || flt != e_flt || sht != e_sht || shdn != (e_flt || e_sht)) begin
      n_fail++;
      $display("FAIL %s actual tmr=%0d flt=%0b sht=%0b shdn=%0b expected tmr=%0d flt=%0b sht=%0b shdn=%0b",
               tag, tmr, flt, sht, shdn, e_tmr, e_flt, e_sht, e_flt || e_sht);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    int r, cur;
    rst_n = 0; isense = '0; vld = 0; vlow = 0; en = 0; clr = 0; lvl = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 tmr", int'(tmr), 0);
    chk("R1 flags", int'({flt, sht, shdn}), 0);
    en = 1;

    // R2 threshold boundaries for every power-level code
    for (int l = 0; l < 4; l++) begin
      lvl = 2'(l);
      for (int d = -1; d <= 1; d++) begin
        step(0, 0, 1, 0, "R7 clear");
        step(thr_of(l) + d, 1, 0, 0, "R2 threshold");
        chk("R2 single step", int'(tmr), (d > 0) ? 1 : 0);
      end
    end

    // R5 trip after exactly TRIP up-steps, R9 shutdown, R11 freeze
    lvl = 2'd1;
    step(0, 0, 1, 0, "R7 clear");
    for (int i = 1; i < TRIP; i++) step(99, 1, 0, 0, "R5 ramp");
    chk("R5 no early trip", int'(flt), 0);
    step(99, 1, 0, 0, "R5 trip edge");
    chk("R5 fault set", int'(flt), 1);
    chk("R5 timer at trip", int'(tmr), TRIP);
    chk("R9 shutdown", int'(shdn), 1);
    for (int i = 0; i < 20; i++) step((i % 2) ? 0 : 500, 1, 0, 0, "R11 frozen");
    chk("R11 timer held", int'(tmr), TRIP);
    chk("R7 fault sticky", int'(flt), 1);
    step(0, 0, 1, 0, "R7 clear");
    chk("R7 cleared", int'({flt, sht, tmr}), 0);

    // R3 slow leak: 10 up, 48 below -> 7
    lvl = 2'd0;
    for (int i = 0; i < 10; i++) step(401, 1, 0, 0, "R3 up");
    for (int i = 0; i < 48; i++) step(400, 1, 0, 0, "R3 leak");
    chk("R3 leak count", int'(tmr), 7);
    // above sample restarts the sixteen-count
    for (int i = 0; i < 10; i++) step(100, 1, 0, 0, "R3 partial");
    step(401, 1, 0, 0, "R3 restart");
    for (int i = 0; i < 15; i++) step(100, 1, 0, 0, "R3 after restart");
    chk("R3 no decrement yet", int'(tmr), 8);
    step(100, 1, 0, 0, "R3 sixteenth");
    chk("R3 decremented", int'(tmr), 7);

    // R4 floor at zero
    step(0, 0, 1, 0, "R7 clear");
    for (int i = 0; i < 40; i++) step(5, 1, 0, 0, "R4 floor");
    step(401, 1, 0, 0, "R4 first up");
    chk("R4 floor then up", int'(tmr), 1);

    // R10 invalid cycles ignored
    for (int i = 0; i < 4; i++) step(401, 1, 0, 0, "R10 setup");
    for (int i = 0; i < 8; i++) step(1000, 0, 0, 0, "R10 idle");
    chk("R10 held", int'(tmr), 5);
    chk("R10 no short", int'(sht), 0);

    // R8 disabled: zero timer, no flags
    en = 0;
    step(900, 1, 0, 0, "R8 disabled");
    step(900, 1, 0, 1, "R8 disabled vlow");
    chk("R8 timer zero", int'(tmr), 0);
    chk("R8 no flags", int'({flt, sht}), 0);
    en = 1;

    // R6 short
    step(800, 1, 0, 0, "R6 at limit");
    chk("R6 800 no short", int'(sht), 0);
    step(801, 1, 0, 0, "R6 above limit");
    chk("R6 short set", int'(sht), 1);
    chk("R9 shutdown short", int'(shdn), 1);
    step(0, 0, 1, 0, "R7 clear");
    step(0, 0, 0, 1, "R6 vout low");
    chk("R6 vlow short", int'(sht), 1);
    step(0, 0, 1, 0, "R7 clear");

    // near-exhaustive mixed sweep
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r  = int'(lf);
      if ((r % 97) == 0) lvl = 2'(r >> 3);
      if ((r % 211) == 0) en = ~en;
      if ((r % 8) == 0) cur = r % 1024;
      else cur = thr_of(int'(lvl)) + (r % 5) - 1 - (((r >> 4) % 2) * 3);
      step(cur, (r % 6) != 0, (r % 389) == 0, (r % 1499) == 0, "R2 R3 R5 sweep");
    end

    finish_run();
  end

endmodule